// File: doc/BRIEF.md
# Two-Half Elastic Slot Buffer with Phase Status

This block is a frame-aligned elastic store built from two halves. Each half holds one frame of byte-wide time slots. A line-side strobe writes one slot per pulse and a system-side strobe reads one slot per pulse. Both sides run on one clock and move at their own rates through their enables. Each side keeps a slot pointer, and the top bit of that pointer names the half the side is working in.

Once per frame, when the line side writes the last slot of a half, the block latches a status byte. The byte holds the write-to-read distance in slots and the two active-half flags. A processor port can read the half the line side is not filling and can write the half the system side is not draining.

If the system side catches up with the line side, the block repeats one whole frame. If the line side is about to run into the system side, the block drops one whole frame. Each case raises its own one-cycle slip pulse.

Top module: `slip_buffer_top`

## Requirements
- R1: While `rst` is high at a clock edge, the write pointer goes to slot 32 and the read pointer goes to slot 0. After that edge `status` is 0x00 and `frame_mark`, `slip_repeat`, `slip_drop`, `rd_valid` and `cpu_rd_valid` are all 0.
- R2: A cycle with `wr_en` high stores `wr_data` at the write pointer and advances the pointer by one, modulo 64. A cycle with `rd_en` high reads the slot at the read pointer and advances that pointer by one. The byte appears on `rd_data` one cycle later, with `rd_valid` high.
- R3: The delay code is the write pointer minus the read pointer, modulo 64, counted in 8-bit slots. It occupies `status[7:2]`. `status[1]` is the write half and `status[0]` is the read half, where 0 means slots 0–31 and 1 means slots 32–63. All three fields are taken from the pointer values just after the latching edge.
- R4: `status` changes only at the edge of a line write to slot 31 or slot 63. `frame_mark` is high for exactly the cycle after each such edge. At all other times `status` holds its value.
- R5: A read issued when the delay is 0 repeats a frame. It returns the slot 32 positions back (the read pointer with its top bit flipped), continues from the slot after that, and pulses `slip_repeat` for one cycle.
- R6: A write without a read, issued when the delay is 63, is stored normally. The read pointer then jumps forward 32 slots, which drops a frame and leaves a delay of 32, and `slip_drop` pulses for one cycle.
- R7: `cpu_rd_en` reads slot `cpu_addr` of the half opposite the current write half. The byte appears on `cpu_rdata` one cycle later, with `cpu_rd_valid` high.
- R8: `cpu_wr_en` writes `cpu_wdata` to slot `cpu_addr` of the half opposite the current read half. The write is discarded when `wr_en` is high in the same cycle.
- R9: `wr_half` and `rd_half` give the live top bits of the write and read pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Line-side slot write strobe |
| wr_data | input | 8 | Line-side slot byte |
| rd_en | input | 1 | System-side slot read strobe |
| rd_data | output | 8 | System-side slot byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_addr | input | 5 | Slot index inside the opposite half |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte |
| cpu_rd_valid | output | 1 | `cpu_rdata` holds a new byte |
| status | output | 8 | Latched {delay, write half, read half} |
| frame_mark | output | 1 | Status was just latched |
| slip_repeat | output | 1 | A frame was repeated |
| slip_drop | output | 1 | A frame was dropped |
| wr_half | output | 1 | Live write half |
| rd_half | output | 1 | Live read half |

## Verification
The hardest case to reach from the ports is a processor write that actually lands where the processor read port can see it. The processor read port looks at the half opposite the writer. The processor write port looks at the half opposite the reader. Both ports cover the same half only when the two pointers sit in one half, which means the delay has to be small. To get there, the stimulus drains the read side until the delay is 3. It then checks a processor write, the same write colliding with a line write, and the read-back of that slot. After that, the stimulus keeps draining until a repeat occurs, and it overfills until a drop occurs.

// File: rtl/slip_buffer_pkg.sv
package slip_buffer_pkg;
  localparam int unsigned DEF_DATA_W     = 8;
  localparam int unsigned DEF_HALF_SLOTS = 32;

  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_kind_e;
endpackage

// File: rtl/slip_ptr_ctrl.sv
module slip_ptr_ctrl
  import slip_buffer_pkg::*;
#(
  parameter int unsigned HALF_SLOTS = DEF_HALF_SLOTS,
  localparam int unsigned PTR_W     = $clog2(HALF_SLOTS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wp_q,
  output logic [PTR_W-1:0] rp_q,
  output logic [PTR_W-1:0] rd_addr,
  output logic [PTR_W-1:0] wp_nxt,
  output logic [PTR_W-1:0] rp_nxt,
  output logic             frame_evt,
  output logic             slip_repeat_q,
  output logic             slip_drop_q
);
  localparam logic [PTR_W-1:0] HALF_SEP = PTR_W'(HALF_SLOTS);
  localparam logic [PTR_W-1:0] GAP_FULL = '1;

  logic [PTR_W-1:0] gap;
  slip_kind_e       kind;

  function automatic logic [PTR_W-1:0] flip_half(input logic [PTR_W-1:0] p);
    return {~p[PTR_W-1], p[PTR_W-2:0]};
  endfunction

  always_comb begin
    gap = wp_q - rp_q;
    if (rd_en && gap == '0)
      kind = SLIP_REPEAT;
    else if (wr_en && !rd_en && gap == GAP_FULL)
      kind = SLIP_DROP;
    else
      kind = SLIP_NONE;

    rd_addr = (kind == SLIP_REPEAT) ? flip_half(rp_q) : rp_q;
    wp_nxt  = wr_en ? wp_q + PTR_W'(1) : wp_q;
    if (rd_en)
      rp_nxt = rd_addr + PTR_W'(1);
    else if (kind == SLIP_DROP)
      rp_nxt = flip_half(rp_q);
    else
      rp_nxt = rp_q;
    frame_evt = wr_en && (&wp_q[PTR_W-2:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q          <= HALF_SEP;
      rp_q          <= '0;
      slip_repeat_q <= 1'b0;
      slip_drop_q   <= 1'b0;
    end else begin
      wp_q          <= wp_nxt;
      rp_q          <= rp_nxt;
      slip_repeat_q <= (kind == SLIP_REPEAT);
      slip_drop_q   <= (kind == SLIP_DROP);
    end
  end

  AST_WP_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wp_q == $past(wp_q) + PTR_W'(1)); // R2
  AST_RP_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |=> $stable(rp_q)); // R2
  AST_DROP_GAP: assert property (@(posedge clk) disable iff (rst)
    slip_drop_q |-> gap == HALF_SEP); // R6
  AST_REPEAT_GAP: assert property (@(posedge clk) disable iff (rst)
    slip_repeat_q |-> (gap == HALF_SEP || gap == HALF_SEP - PTR_W'(1))); // R5
  AST_ONE_SLIP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({slip_repeat_q, slip_drop_q})); // R5
endmodule

// File: rtl/slip_mem.sv
module slip_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 6,
  localparam int unsigned DEPTH = 1 << PTR_W
) (
  input  logic              clk,
  input  logic              line_we,
  input  logic [PTR_W-1:0]  line_addr,
  input  logic [DATA_W-1:0] line_data,
  input  logic              cpu_we,
  input  logic [PTR_W-1:0]  cpu_waddr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              sys_re,
  input  logic [PTR_W-1:0]  sys_addr,
  output logic [DATA_W-1:0] sys_q,
  input  logic              cpu_re,
  input  logic [PTR_W-1:0]  cpu_raddr,
  output logic [DATA_W-1:0] cpu_q
);
  logic [DATA_W-1:0] store [DEPTH];
  logic              we;
  logic [PTR_W-1:0]  waddr;
  logic [DATA_W-1:0] wdata;

  always_comb begin
    we    = line_we || cpu_we;
    waddr = line_we ? line_addr : cpu_waddr;
    wdata = line_we ? line_data : cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (we)
      store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (sys_re)
      sys_q <= store[sys_addr];
  end

  always_ff @(posedge clk) begin
    if (cpu_re)
      cpu_q <= store[cpu_raddr];
  end
endmodule

// File: rtl/slip_status.sv
module slip_status #(
  parameter int unsigned PTR_W = 6,
  localparam int unsigned ST_W = PTR_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_evt,
  input  logic [PTR_W-1:0] wp_nxt,
  input  logic [PTR_W-1:0] rp_nxt,
  output logic [ST_W-1:0]  status_q,
  output logic             frame_mark_q
);
  logic [PTR_W-1:0] delay_code;

  always_comb delay_code = wp_nxt - rp_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q     <= '0;
      frame_mark_q <= 1'b0;
    end else begin
      frame_mark_q <= frame_evt;
      if (frame_evt)
        status_q <= {delay_code, wp_nxt[PTR_W-1], rp_nxt[PTR_W-1]};
    end
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_evt |=> $stable(status_q)); // R4
  AST_MARK_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    frame_evt |=> frame_mark_q); // R4
endmodule

// File: rtl/slip_buffer_top.sv
module slip_buffer_top
  import slip_buffer_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned HALF_SLOTS = DEF_HALF_SLOTS,
  localparam int unsigned SLOT_W    = $clog2(HALF_SLOTS),
  localparam int unsigned PTR_W     = SLOT_W + 1,
  localparam int unsigned ST_W      = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              cpu_rd_en,
  input  logic              cpu_wr_en,
  input  logic [SLOT_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rd_valid,
  output logic [ST_W-1:0]   status,
  output logic              frame_mark,
  output logic              slip_repeat,
  output logic              slip_drop,
  output logic              wr_half,
  output logic              rd_half
);
  logic [PTR_W-1:0] wp_q, rp_q, rd_addr, wp_nxt, rp_nxt;
  logic             frame_evt;
  logic [PTR_W-1:0] cpu_raddr, cpu_waddr;
  logic             cpu_we_eff;

  slip_ptr_ctrl #(.HALF_SLOTS(HALF_SLOTS)) u_ptr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .wp_q(wp_q), .rp_q(rp_q), .rd_addr(rd_addr),
    .wp_nxt(wp_nxt), .rp_nxt(rp_nxt), .frame_evt(frame_evt),
    .slip_repeat_q(slip_repeat), .slip_drop_q(slip_drop)
  );

  always_comb begin
    cpu_raddr  = {~wp_q[PTR_W-1], cpu_addr};
    cpu_waddr  = {~rp_q[PTR_W-1], cpu_addr};
    cpu_we_eff = cpu_wr_en && !wr_en;
    wr_half    = wp_q[PTR_W-1];
    rd_half    = rp_q[PTR_W-1];
  end

  slip_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk(clk),
    .line_we(wr_en), .line_addr(wp_q), .line_data(wr_data),
    .cpu_we(cpu_we_eff), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
    .sys_re(rd_en), .sys_addr(rd_addr), .sys_q(rd_data),
    .cpu_re(cpu_rd_en), .cpu_raddr(cpu_raddr), .cpu_q(cpu_rdata)
  );

  slip_status #(.PTR_W(PTR_W)) u_status (
    .clk(clk), .rst(rst), .frame_evt(frame_evt),
    .wp_nxt(wp_nxt), .rp_nxt(rp_nxt),
    .status_q(status), .frame_mark_q(frame_mark)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      cpu_rd_valid <= 1'b0;
    end else begin
      rd_valid     <= rd_en;
      cpu_rd_valid <= cpu_rd_en;
    end
  end

  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R2
  AST_CPU_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_en |=> cpu_rd_valid); // R7
endmodule

// File: tb/slip_buffer_top_test.sv
module slip_buffer_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, cpu_rd_en = 1'b0, cpu_wr_en = 1'b0;
  logic [7:0] wr_data = '0, cpu_wdata = '0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] rd_data, cpu_rdata, status;
  logic       rd_valid, cpu_rd_valid, frame_mark, slip_repeat, slip_drop;
  logic       wr_half, rd_half;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] m_mem [64];
  bit         m_ok  [64];
  logic [5:0] m_wp, m_rp;
  logic [7:0] m_status;

  logic [8:0] sys_q[$];
  string      sys_tag[$];
  logic [8:0] cpu_q[$];
  string      cpu_tag[$];

  always #2 clk = ~clk;

  slip_buffer_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .cpu_rd_en(cpu_rd_en), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rd_valid(cpu_rd_valid),
    .status(status), .frame_mark(frame_mark), .slip_repeat(slip_repeat),
    .slip_drop(slip_drop), .wr_half(wr_half), .rd_half(rd_half)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard as read results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (sys_q.size() == 0) chk("R2 unexpected rd_valid", 1, 0);
        else begin
          logic [8:0] e;
          string t;
          e = sys_q.pop_front();
          t = sys_tag.pop_front();
          if (e[8]) chk(t, {24'd0, rd_data}, {24'd0, e[7:0]});
        end
      end
      if (cpu_rd_valid) begin
        if (cpu_q.size() == 0) chk("R7 unexpected cpu_rd_valid", 1, 0);
        else begin
          logic [8:0] e;
          string t;
          e = cpu_q.pop_front();
          t = cpu_tag.pop_front();
          if (e[8]) chk(t, {24'd0, cpu_rdata}, {24'd0, e[7:0]});
        end
      end
    end
  end

  function automatic logic [5:0] gap();
    return m_wp - m_rp;
  endfunction

  task automatic step(input logic we, input logic [7:0] wd, input logic re,
                      input logic cre, input logic cwe, input logic [4:0] ca,
                      input logic [7:0] cwd, input string tag);
    logic [5:0] d, ra, wpn, rpn;
    logic       und, ovf, frm;
    @(negedge clk);
    wr_en = we; wr_data = wd; rd_en = re;
    cpu_rd_en = cre; cpu_wr_en = cwe; cpu_addr = ca; cpu_wdata = cwd;
    d   = m_wp - m_rp;
    und = re && d == 6'd0;
    ovf = we && !re && d == 6'd63;
    frm = we && m_wp[4:0] == 5'd31;
    if (cre) begin
      cpu_q.push_back({m_ok[{~m_wp[5], ca}], m_mem[{~m_wp[5], ca}]});
      cpu_tag.push_back({tag, " R7 cpu read"});
    end
    ra  = und ? {~m_rp[5], m_rp[4:0]} : m_rp;
    rpn = m_rp;
    if (re) begin
      sys_q.push_back({m_ok[ra], m_mem[ra]});
      sys_tag.push_back({tag, und ? " R5 repeat data" : " R2 read data"});
      rpn = ra + 6'd1;
    end
    if (cwe && !we) begin
      m_mem[{~m_rp[5], ca}] = cwd;
      m_ok[{~m_rp[5], ca}]  = 1'b1;
    end
    wpn = m_wp;
    if (we) begin
      m_mem[m_wp] = wd;
      m_ok[m_wp]  = 1'b1;
      wpn = m_wp + 6'd1;
      if (ovf) rpn = {~m_rp[5], m_rp[4:0]};
    end
    m_wp = wpn;
    m_rp = rpn;
    if (frm) m_status = {wpn - rpn, wpn[5], rpn[5]};
    @(posedge clk);
    #1;
    chk({tag, " R3 R4 status"}, {24'd0, status}, {24'd0, m_status});
    chk({tag, " R4 frame_mark"}, {31'd0, frame_mark}, {31'd0, frm});
    chk({tag, " R5 slip_repeat"}, {31'd0, slip_repeat}, {31'd0, und});
    chk({tag, " R6 slip_drop"}, {31'd0, slip_drop}, {31'd0, ovf});
    chk({tag, " R9 halves"}, {30'd0, wr_half, rd_half}, {30'd0, m_wp[5], m_rp[5]});
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_ok[i] = 1'b0; m_mem[i] = '0; end
    m_wp = 6'd32; m_rp = 6'd0; m_status = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 status", {24'd0, status}, 32'h0);
    chk("R1 strobes", {27'd0, frame_mark, slip_repeat, slip_drop, rd_valid, cpu_rd_valid}, 32'h0);
    chk("R1 R9 halves", {30'd0, wr_half, rd_half}, 32'h2);
    @(negedge clk);
    rst = 1'b0;

    // R2 steady flow, delay 32, crosses two frame ends
    for (int i = 0; i < 64; i++) step(1, 8'(i + 8'h10), 1, 0, 0, '0, '0, "P1");
    // R3 unequal rates then a frame end with delay 37
    for (int i = 0; i < 10; i++) step(1, 8'(i + 8'h60), 0, 0, 0, '0, '0, "P2w");
    for (int i = 0; i < 5; i++)  step(0, '0, 1, 0, 0, '0, '0, "P2r");
    for (int i = 0; i < 40; i++) step(1, 8'(i + 8'h80), 1, 0, 0, '0, '0, "P2b");
    // R7 cpu read of opposite write half
    for (int i = 0; i < 4; i++) step(0, '0, 0, 1, 0, 5'(i * 7), '0, "P3 R7");
    // bring both pointers into one half
    while (gap() != 6'd3) step(0, '0, 1, 0, 0, '0, '0, "P4 drain");
    // R8 cpu write visible through cpu read, then a blocked write
    step(0, '0, 0, 0, 1, 5'd20, 8'hA5, "P5 R8 write");
    step(0, '0, 0, 1, 0, 5'd20, '0, "P5 R8 readback");
    step(1, 8'h77, 0, 0, 1, 5'd20, 8'h5A, "P5 R8 blocked");
    step(0, '0, 0, 1, 0, 5'd20, '0, "P5 R8 readback2");
    // R5 underflow, with and without a concurrent write
    while (gap() != 6'd0) step(0, '0, 1, 0, 0, '0, '0, "P6 drain");
    step(0, '0, 1, 0, 0, '0, '0, "P6 R5");
    step(0, '0, 1, 0, 0, '0, '0, "P6 after");
    while (gap() != 6'd0) step(0, '0, 1, 0, 0, '0, '0, "P6b drain");
    step(1, 8'hC3, 1, 0, 0, '0, '0, "P6b R5 with write");
    // R6 overflow drop
    while (gap() != 6'd63) step(1, 8'(gap() + 8'h20), 0, 0, 0, '0, '0, "P7 fill");
    step(1, 8'hEE, 0, 0, 0, '0, '0, "P7 R6");
    for (int i = 0; i < 40; i++) step(1, 8'(i), 1, 0, 0, '0, '0, "P8");
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 0, '0, '0, "idle");
    chk("R2 scoreboard drained", sys_q.size() + cpu_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule